// File: doc/BRIEF.md
# Device Bus Address Map with Page Translator

This block holds a table of 32 physical base addresses, one for each 8 KB page of an 18-bit device bus. Device addresses are translated into a 22-bit physical memory space through this table. A 16-bit register port is used to load and inspect the table. Each 22-bit base occupies two consecutive 16-bit registers: a low word and a high word. The port accepts both full-word writes and single-byte writes. Bit 0 of every base is always zero, so bases are word aligned.

A translation request takes the page number from the top five bits of the device address and the offset from the low 13 bits. In every page except the highest, the result is the stored base plus the offset, wrapped to 22 bits. The highest page is never looked up in the table. It always lands on the fixed I/O window at 0x3FE000 plus the offset. With the global map enable low, the table is skipped and the device address passes through zero-extended. The result is registered and is held until the next request.

Top module: `bus_map_xlate`

## Requirements
- R1: After reset every table entry reads as zero on both of its words, and `physAddr` is zero.
- R2: The entry addressed by the register port is `regAddr[6:2]`. `regAddr[1]` selects the high word (1) or the low word (0). For word accesses `regAddr[0]` is ignored.
- R3: A low-word read returns entry bits 15..1 in `regRdata[15:1]`, and `regRdata[0]` is 0.
- R4: A high-word read returns entry bits 21..16 in `regRdata[5:0]`, and `regRdata[15:6]` is 0.
- R5: A word write (`regByte`=0) replaces entry bits 15..0 when `regAddr[1]`=0, with data bit 0 dropped. It replaces bits 21..16 from `regWdata[5:0]` when `regAddr[1]`=1. Other entry bits are unchanged.
- R6: A byte write (`regByte`=1) uses lane `regAddr[1:0]` and only `regWdata[7:0]`. Lane 0 sets entry bits 7..1, with bit 0 kept at 0. Lane 1 sets bits 15..8. Lane 2 sets bits 21..16 from data bits 5..0. Lane 3 changes nothing. Bytes outside the lane are unchanged.
- R7: With `mapEnable`=1 and a page below 31, a request yields (entry[page] + `busAddr[12:0]`) mod 2^22 on `physAddr` one clock after `xlateReq`.
- R8: With `mapEnable`=1 and page 31, a request yields 0x3FE000 + `busAddr[12:0]`, whatever entry 31 holds.
- R9: With `mapEnable`=0, a request yields `busAddr` zero-extended to 22 bits.
- R10: `physAddr` holds its value in every cycle without `xlateReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regByte | input | 1 | 1 = byte write, 0 = word write |
| regAddr | input | 7 | Register byte address (entry, word, lane) |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` (combinational) |
| mapEnable | input | 1 | 1 = translate through table, 0 = pass through |
| xlateReq | input | 1 | Translation request strobe |
| busAddr | input | 18 | Device bus address to translate |
| physAddr | output | 22 | Last translated physical address |

## Verification
The hardest case to reach is the 22-bit wraparound of base plus offset. It needs a base loaded close to the top of physical space and then an offset that crosses it. The bench builds such bases with byte writes in lanes 0 to 2 and sweeps offsets 0, 1, 0x1000 and 0x1FFF across all 32 pages. Lane 3 byte writes and high-word bits above the entry width are sent on purpose. Both words are then read back to show that nothing leaked into the entry.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  localparam int MAP_ENTRIES = 32;
  localparam int PHYS_W      = 22;
  localparam int BUS_W       = 18;
  localparam int REG_W       = 16;
  localparam int PAGE_OFF_W  = 13;
  localparam int IDX_W       = $clog2(MAP_ENTRIES);
  localparam int RADDR_W     = IDX_W + 2;
  localparam int HI_W        = PHYS_W - REG_W;
  localparam int WIDE_W      = 2 * REG_W;
  localparam logic [PHYS_W-1:0] IO_BASE = 22'o17760000;

  typedef struct packed {
    logic             wrEn;
    logic             byteMode;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lane;
    logic             xlate;
  } mapStrobes_t;
endpackage

// File: rtl/bmap_ctrl.sv
module bmap_ctrl
  import bmap_pkg::*;
(
  input  logic               regWrEn,
  input  logic               regByte,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic               xlateReq,
  output mapStrobes_t        stb
);
  always_comb begin
    stb.wrEn     = regWrEn;
    stb.byteMode = regByte;
    stb.idx      = regAddr[RADDR_W-1:2];
    stb.lane     = regAddr[1:0];
    stb.xlate    = xlateReq;
  end
endmodule

// File: rtl/bmap_datapath.sv
module bmap_datapath
  import bmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobes_t       stb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              mapEnable,
  input  logic [BUS_W-1:0]  busAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [PHYS_W-1:0] physAddr
);
  localparam int PAGE_W = BUS_W - PAGE_OFF_W;
  localparam logic [PAGE_W-1:0] TOP_PAGE = '1;

  logic [PHYS_W-1:0] entryArr [MAP_ENTRIES];
  logic [PHYS_W-1:0] selEntry;
  logic [WIDE_W-1:0] laneMask, laneData, merged;
  logic [PHYS_W-1:0] storeVal;
  logic [4:0]        shiftAmt;

  // write merge: place data at the lane shift, keep other bytes
  always_comb begin
    selEntry = entryArr[stb.idx];
    if (stb.byteMode) begin
      shiftAmt = {stb.lane, 3'b000};
      laneMask = {{(WIDE_W-8){1'b0}}, 8'hFF} << shiftAmt;
      laneData = {{(WIDE_W-8){1'b0}}, wrData[7:0]} << shiftAmt;
    end else begin
      shiftAmt = {stb.lane[1], 4'b0000};
      laneMask = {{(WIDE_W-REG_W){1'b0}}, {REG_W{1'b1}}} << shiftAmt;
      laneData = {{(WIDE_W-REG_W){1'b0}}, wrData} << shiftAmt;
    end
    merged   = ({{(WIDE_W-PHYS_W){1'b0}}, selEntry} & ~laneMask) | laneData;
    storeVal = {merged[PHYS_W-1:1], 1'b0};
  end

  for (genvar i = 0; i < MAP_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        entryArr[i] <= '0;
      else if (stb.wrEn && (stb.idx == IDX_W'(i)))
        entryArr[i] <= storeVal;
    end
  end

  // register read
  always_comb begin
    if (stb.lane[1])
      rdData = {{(REG_W-HI_W){1'b0}}, selEntry[PHYS_W-1:REG_W]};
    else
      rdData = {selEntry[REG_W-1:1], 1'b0};
  end

  // translator
  logic [PAGE_W-1:0]     pageNum;
  logic [PAGE_OFF_W-1:0] pageOff;
  logic [PHYS_W-1:0]     nextPhys;

  always_comb begin
    pageNum = busAddr[BUS_W-1:PAGE_OFF_W];
    pageOff = busAddr[PAGE_OFF_W-1:0];
    if (!mapEnable)
      nextPhys = PHYS_W'(busAddr);
    else if (pageNum == TOP_PAGE)
      nextPhys = IO_BASE + PHYS_W'(pageOff);
    else
      nextPhys = entryArr[pageNum] + PHYS_W'(pageOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      physAddr <= '0;
    else if (stb.xlate)
      physAddr <= nextPhys;
  end

  // R3
  lo_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.lane[1] |-> rdData[0] == 1'b0);

  // R4
  hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.lane[1] |-> rdData[REG_W-1:HI_W] == '0);

  // R6
  lane3_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.byteMode && stb.lane == 2'd3 && !stb.xlate)
      |=> entryArr[$past(stb.idx)] == $past(selEntry));

  // R8
  io_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xlate && mapEnable && pageNum == TOP_PAGE)
      |=> physAddr[PHYS_W-1:PAGE_OFF_W] == IO_BASE[PHYS_W-1:PAGE_OFF_W]);

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.xlate && !mapEnable) |=> physAddr == PHYS_W'($past(busAddr)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xlate |=> $stable(physAddr));
endmodule

// File: rtl/bus_map_xlate.sv
module bus_map_xlate
  import bmap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regByte,
  input  logic [RADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic               mapEnable,
  input  logic               xlateReq,
  input  logic [BUS_W-1:0]   busAddr,
  output logic [PHYS_W-1:0]  physAddr
);
  mapStrobes_t stb;

  bmap_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regByte (regByte),
    .regAddr (regAddr),
    .xlateReq(xlateReq),
    .stb     (stb)
  );

  bmap_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWdata),
    .mapEnable(mapEnable),
    .busAddr  (busAddr),
    .rdData   (regRdata),
    .physAddr (physAddr)
  );
endmodule

// File: tb/bus_map_xlate_tb.sv
module bus_map_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regByte = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        mapEnable = 1'b0, xlateReq = 1'b0;
  logic [17:0] busAddr = '0;
  logic [21:0] physAddr;

  int testCount = 0, failCount = 0;
  logic [21:0] model [32];

  always #2 clk = ~clk;

  bus_map_xlate u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regByte(regByte),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .mapEnable(mapEnable), .xlateReq(xlateReq), .busAddr(busAddr),
    .physAddr(physAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model of a register write, computed from the shift rules
  task automatic wr(input logic [6:0] a, input logic isByte, input logic [15:0] d);
    logic [31:0] v, msk, dat;
    int sc;
    v = {10'b0, model[a[6:2]]};
    if (isByte) begin sc = a[1:0] * 8; msk = 32'hFF << sc; dat = {24'b0, d[7:0]} << sc; end
    else        begin sc = a[1] * 16;  msk = 32'hFFFF << sc; dat = {16'b0, d} << sc; end
    v = ((v & ~msk) | dat) & 32'h003F_FFFE;
    model[a[6:2]] = v[21:0];
    @(negedge clk);
    regAddr = a; regByte = isByte; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input int e);
    @(negedge clk);
    regAddr = {e[4:0], 2'b00}; #1;
    check(req, {16'b0, regRdata}, {16'b0, model[e][15:1], 1'b0});
    regAddr = {e[4:0], 2'b10}; #1;
    check(req, {16'b0, regRdata}, {26'b0, model[e][21:16]});
  endtask

  task automatic xl(input string req, input logic en, input logic [17:0] ba);
    logic [21:0] exp;
    if (!en) exp = {4'b0, ba};
    else if (ba[17:13] == 5'd31) exp = 22'h3FE000 + {9'b0, ba[12:0]};
    else exp = model[ba[17:13]] + {9'b0, ba[12:0]};
    @(negedge clk);
    mapEnable = en; busAddr = ba; xlateReq = 1'b1;
    @(negedge clk);
    xlateReq = 1'b0;
    check(req, {10'b0, physAddr}, {10'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [12:0] offs [4];
    offs[0] = 13'h0; offs[1] = 13'h1; offs[2] = 13'h1000; offs[3] = 13'h1FFF;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of all 64 words and the result register
    for (int e = 0; e < 32; e++) rdChk("R1", e);
    check("R1", {10'b0, physAddr}, 32'h0);

    // R2 R3 R4 R5: word writes to every entry, odd data bits and byte addr bit 0 set
    for (int e = 0; e < 32; e++) begin
      wr({e[4:0], 2'b01}, 1'b0, 16'hA5A5 ^ {e[4:0], 11'h0F3});
      wr({e[4:0], 2'b11}, 1'b0, 16'hFFC0 | {11'b0, e[4:0]} ^ 16'h0015);
      rdChk("R5", e);
    end

    // R6: byte writes on each lane, including lane 3 and high bits of lane 2
    for (int e = 0; e < 32; e += 3) begin
      for (int ln = 0; ln < 4; ln++) begin
        wr({e[4:0], ln[1:0]}, 1'b1, 8'hFF ^ 8'(e * 7 + ln));
        rdChk("R6", e);
      end
    end

    // near-top bases for wraparound
    wr({5'd5, 2'b00}, 1'b1, 16'h00FF);
    wr({5'd5, 2'b01}, 1'b1, 16'h00F8);
    wr({5'd5, 2'b10}, 1'b1, 16'h003F);
    rdChk("R6", 5);
    wr({5'd31, 2'b00}, 1'b0, 16'h1234);

    // R7 R8: full page sweep with map on
    for (int p = 0; p < 32; p++)
      for (int k = 0; k < 4; k++)
        xl(p == 31 ? "R8" : "R7", 1'b1, {p[4:0], offs[k]});

    // R9: map off sweep
    for (int p = 0; p < 32; p += 5)
      for (int k = 0; k < 4; k++)
        xl("R9", 1'b0, {p[4:0], offs[k]});

    // R10: hold without request
    xl("R7", 1'b1, {5'd5, 13'h1FFF});
    begin
      logic [21:0] held;
      held = physAddr;
      @(negedge clk); busAddr = 18'h2ABCD; mapEnable = 1'b0;
      wr({5'd5, 2'b00}, 1'b0, 16'h0000);
      @(negedge clk);
      check("R10", {10'b0, physAddr}, {10'b0, held});
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule